// File: doc/BRIEF.md
# Fetch-Aware Upper Address Folding and Bank Steering

This block turns the top two bits of a 16-bit processor address into the upper address lines of a larger physical RAM. It applies two rules at once. During an opcode fetch (the fetch strobe `fetch_n` is low) with address bit 14 set, the physical bit 15 is forced low. As a result, instruction fetches from the top 16k land on the mirror of the 16k–32k region. Whenever the physical bit 15 ends up high, one extra physical line per bank-select bit is driven from a static bank selector. This splits the upper 32k of the processor map into several banks.

The whole block is combinational. No register lies between any input and any output. It sits in the address path of an external memory decoder. Chip selects, refresh addressing and any software-visible paging register live elsewhere.

A parameter sets the number of upper banks. With the default of two banks there is a single bank line, which serves as physical address bit 16 and gives a 96k RAM array. A second parameter removes fetch folding for systems that do not need the mirror.

Top module: `fold_bank_map`

## Requirements
- R1: With folding enabled, when `fetch_n` is 0 and `cpu_a14` is 1, `ram_a15` is 0.
- R2: Whenever `ram_a15` is 1, `ram_bank` equals `bank_sel` bit for bit.
- R3: When `cpu_a15` is 0 (processor addresses 0–32k), `ram_a15` is 0 and `ram_bank` is all zeros, whatever the values of `fetch_n`, `cpu_a14` and `bank_sel`.
- R4: An opcode fetch (`fetch_n` = 0) with `cpu_a15` = 1 and `cpu_a14` = 1 (48k–64k) gives `ram_a15` = 0 and `ram_bank` = 0 for every `bank_sel` value. The access therefore lands on the unbanked 16k–32k mirror.
- R5: When `fetch_n` is 1, `ram_a15` equals `cpu_a15`. For 48k–64k and 32k–48k accesses, `ram_bank` then equals `bank_sel`, so reads and writes reach the selected bank.
- R6: An opcode fetch with `cpu_a15` = 1 and `cpu_a14` = 0 (32k–48k) is not folded. `ram_a15` is 1 and `ram_bank` follows `bank_sel`.
- R7: Outputs follow inputs combinationally: a new input value is visible on the outputs without any clock edge.
- R8: With `FOLD_FETCH` = 0, `ram_a15` equals `cpu_a15` for every `fetch_n` value, and the bank rules R2 and R3 still hold.
- R9: `BANK_COUNT` must be a power of two and at least 2. `ram_bank` and `bank_sel` are `$clog2(BANK_COUNT)` bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_a14 | input | 1 | Processor address bit 14 |
| cpu_a15 | input | 1 | Processor address bit 15 |
| fetch_n | input | 1 | Active-low opcode fetch strobe |
| bank_sel | input | $clog2(BANK_COUNT) | Static upper-bank selector (jumper or control bit) |
| ram_a15 | output | 1 | Physical RAM address bit 15 after folding |
| ram_bank | output | $clog2(BANK_COUNT) | Physical bank lines above bit 15 (bit 0 is physical A16) |

## Verification
The bench builds one instance with `BANK_COUNT` = 4 and folding enabled. This puts a two-bit bank selector within reach, so each bank line is shown to be steered independently. A second instance uses `BANK_COUNT` = 2 with `FOLD_FETCH` = 0, which covers the variant without folding at the default single-line width. Every combination of fetch strobe, both address bits and every selector value is applied to each instance. Expected outputs are derived from the region and fetch rules, and one input change is checked without any clock edge in between.

// File: rtl/fold_bank_pkg.sv
package fold_bank_pkg;
   // Processor 16k region, encoded as {a15, a14}
   typedef enum logic [1:0] {
      RGN_BASE   = 2'b00,   // 0k-16k
      RGN_MIRROR = 2'b01,   // 16k-32k
      RGN_LOWER  = 2'b10,   // 32k-48k
      RGN_UPPER  = 2'b11    // 48k-64k
   } region_t;

   function automatic bit is_pow2_min2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/fold_bank_region.sv
module fold_bank_region
   import fold_bank_pkg::*;
(
   input  logic    a14,
   input  logic    a15,
   output region_t region
);
   always_comb begin
      unique case ({a15, a14})
         2'b00:   region = RGN_BASE;
         2'b01:   region = RGN_MIRROR;
         2'b10:   region = RGN_LOWER;
         default: region = RGN_UPPER;
      endcase
   end
endmodule

// File: rtl/fold_bank_fold.sv
module fold_bank_fold
   import fold_bank_pkg::*;
#(
   parameter bit FOLD_FETCH = 1'b1
)(
   input  region_t region,
   input  logic    fetch_n,
   output logic    phys_a15
);
   generate
      if (FOLD_FETCH) begin : g_fold
         // During a fetch the top 16k collapses onto the 16k-32k mirror
         always_comb begin
            unique case (region)
               RGN_LOWER: phys_a15 = 1'b1;
               RGN_UPPER: phys_a15 = fetch_n;
               default:   phys_a15 = 1'b0;
            endcase
         end
      end else begin : g_pass
         logic unused_fetch;
         assign unused_fetch = fetch_n;
         assign phys_a15 = (region == RGN_LOWER) || (region == RGN_UPPER);
      end
   endgenerate
endmodule

// File: rtl/fold_bank_steer.sv
module fold_bank_steer #(
   parameter int BANK_W = 1
)(
   input  logic              phys_a15,
   input  logic [BANK_W-1:0] bank_sel,
   output logic [BANK_W-1:0] bank_out
);
   generate
      for (genvar i = 0; i < BANK_W; i++) begin : g_line
         assign bank_out[i] = phys_a15 & bank_sel[i];
      end
   endgenerate
endmodule

// File: rtl/fold_bank_map.sv
module fold_bank_map
   import fold_bank_pkg::*;
#(
   parameter int BANK_COUNT = 2,
   parameter bit FOLD_FETCH = 1'b1,
   localparam int BANK_W    = $clog2(BANK_COUNT)
)(
   input  logic              cpu_a14,
   input  logic              cpu_a15,
   input  logic              fetch_n,
   input  logic [BANK_W-1:0] bank_sel,
   output logic              ram_a15,
   output logic [BANK_W-1:0] ram_bank
);
   // R9: elaboration-time parameter check
   generate
      if (!is_pow2_min2(BANK_COUNT)) begin : g_bad_bank_count
         $error("fold_bank_map: BANK_COUNT must be a power of two, at least 2");
      end
   endgenerate

   region_t region;
   logic    phys_a15;

   fold_bank_region u_region (
      .a14    (cpu_a14),
      .a15    (cpu_a15),
      .region (region)
   );

   fold_bank_fold #(.FOLD_FETCH(FOLD_FETCH)) u_fold (
      .region   (region),
      .fetch_n  (fetch_n),
      .phys_a15 (phys_a15)
   );

   fold_bank_steer #(.BANK_W(BANK_W)) u_steer (
      .phys_a15 (phys_a15),
      .bank_sel (bank_sel),
      .bank_out (ram_bank)
   );

   assign ram_a15 = phys_a15;
endmodule

// File: rtl/fold_bank_map_chk.sv
module fold_bank_map_chk #(
   parameter int BANK_COUNT = 2,
   parameter bit FOLD_FETCH = 1'b1,
   localparam int BANK_W    = $clog2(BANK_COUNT)
)(
   input logic              cpu_a14,
   input logic              cpu_a15,
   input logic              fetch_n,
   input logic [BANK_W-1:0] bank_sel,
   input logic              ram_a15,
   input logic [BANK_W-1:0] ram_bank
);
   always_comb begin
      if (FOLD_FETCH && !fetch_n && cpu_a14)
         assert_fetch_fold_R1: assert (ram_a15 == 1'b0);
      if (ram_a15)
         assert_bank_follow_R2: assert (ram_bank == bank_sel);
      if (!cpu_a15)
         assert_low_unpaged_R3: assert (!ram_a15 && ram_bank == '0);
      if (fetch_n)
         assert_nonfetch_pass_R5: assert (ram_a15 == cpu_a15);
      if (!fetch_n && cpu_a15 && !cpu_a14)
         assert_lower_fetch_R6: assert (ram_a15 && ram_bank == bank_sel);
      if (!FOLD_FETCH)
         assert_nofold_R8: assert (ram_a15 == cpu_a15);
   end
endmodule

bind fold_bank_map fold_bank_map_chk #(
   .BANK_COUNT (BANK_COUNT),
   .FOLD_FETCH (FOLD_FETCH)
) u_chk (.*);

// File: tb/sim_fold_bank_map.sv
`timescale 1ns/1ps
module sim_fold_bank_map;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;   // 250 MHz

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // u0: four banks, folding on
   logic       a14, a15, fn;
   logic [1:0] bs;
   logic       ra15;
   logic [1:0] rbank;
   fold_bank_map #(.BANK_COUNT(4), .FOLD_FETCH(1'b1)) u0 (
      .cpu_a14(a14), .cpu_a15(a15), .fetch_n(fn), .bank_sel(bs),
      .ram_a15(ra15), .ram_bank(rbank));

   // u1: two banks, folding off
   logic       b14, b15, gn;
   logic [0:0] cs;
   logic       sa15;
   logic [0:0] sbank;
   fold_bank_map #(.BANK_COUNT(2), .FOLD_FETCH(1'b0)) u1 (
      .cpu_a14(b14), .cpu_a15(b15), .fetch_n(gn), .bank_sel(cs),
      .ram_a15(sa15), .ram_bank(sbank));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input bit f_n, input bit x14, input bit x15);
      if (!x15)                  return "R3";
      if (!f_n && x14)           return "R4";
      if (!f_n && !x14)          return "R6";
      return "R5";
   endfunction

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      a14 = 0; a15 = 0; fn = 1; bs = 2'b11;
      b14 = 0; b15 = 0; gn = 1; cs = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: base region, no bank lines despite selector set (R3)
      chk("R3 reset a15", ra15, 0);
      chk("R3 reset bank", rbank, 0);
      rst = 1'b0;

      // u0 exhaustive sweep
      for (int v = 0; v < 32; v++) begin
         bit f_n, x14, x15;
         int sel, e15, ebank;
         string t;
         @(negedge clk);
         f_n = v[4]; x14 = v[3]; x15 = v[2]; sel = v[1:0];
         fn = f_n; a14 = x14; a15 = x15; bs = 2'(sel);
         #1;
         // expected: fold only for fetch with a14 set (R1)
         e15   = (x15 && !(!f_n && x14)) ? 1 : 0;
         ebank = e15 ? sel : 0;   // R2
         t = tag_of(f_n, x14, x15);
         if (!f_n && x14) chk("R1 fold", ra15, 0);
         chk({t, " a15"}, ra15, e15);
         chk({t, " bank R2"}, rbank, ebank);
      end

      // R7: change input with no clock edge in between
      @(negedge clk);
      fn = 1; a14 = 1; a15 = 1; bs = 2'b10;
      #0.5;
      chk("R7 pre", rbank, 2);
      fn = 0;
      #0.5;
      chk("R7 post a15", ra15, 0);
      chk("R7 post bank", rbank, 0);

      // u1 exhaustive sweep, no folding (R8)
      for (int v = 0; v < 16; v++) begin
         bit f_n, x14, x15, sel;
         @(negedge clk);
         f_n = v[3]; x14 = v[2]; x15 = v[1]; sel = v[0];
         gn = f_n; b14 = x14; b15 = x15; cs = sel;
         #1;
         chk("R8 a15", sa15, x15 ? 1 : 0);
         chk("R8 bank", sbank, (x15 && sel) ? 1 : 0);
      end

      // R9: widths derived from BANK_COUNT
      chk("R9 width u0", $bits(rbank), 2);
      chk("R9 width u1", $bits(sbank), 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule